// File: doc/BRIEF.md
# Framebuffer DMA Line Fetcher

This block reads one frame of pixel data from memory as 32-bit words and keeps a pixel FIFO topped up for the display timing logic that drains it. The frame is described by a base byte address, a total size in words, a visible line length in words and a per-line byte skip. The skip lets a visible window sit inside a wider virtual image, so the picture can be panned. A 5-bit sub-word pixel offset travels with the active settings and tells the downstream serialiser which bit of the first word on each line to start from.

Settings on the configuration inputs are captured only when an update request pulses. They become active at the next frame boundary, or at once while the engine is stopped. Memory traffic goes out as bursts on a simple request/grant read interface, and only one burst is in flight at a time. A new burst starts only while the FIFO fill level is at or below a threshold derived from the burst length. Two sticky error flags, one for underflow and one for overwrite, and a busy indication complete the block.

Top module: `fbdma_fetch`

## Requirements
- R1: After reset, busy, rd_req, pix_vld, err_underflow, err_overwrite, fifo_lvl and pix_off are all zero.
- R2: Word k of a frame with line length L words and skip S bytes is fetched from base + (k / L) * (4L + S) + 4 * (k mod L). Words leave on pix_data in fetch order, with pix_vld high in the cycle after the pop that took them.
- R3: Each burst carries rd_len + 1 words, where rd_len is the burst length minus one. A burst never holds more than cfg_burst_m1 + 1 words and never crosses the end of a line or of the frame. An ungranted request holds rd_req and rd_addr while enabled.
- R4: After the last word of a frame has been requested, the next request starts again at the active base address.
- R5: Changing the configuration inputs without an update request has no effect on the fetched addresses or on pix_off.
- R6: Settings captured by an update request become active at the start of the next frame, and pix_off shows the active 5-bit pixel offset. While the engine is stopped they become active within two cycles.
- R7: A new burst is issued only while fifo_lvl is at or below FIFO_DEPTH - (2 * (cfg_burst_m1 + 1) + 3). With no pops the level settles at the first multiple of the burst above that threshold, and it never exceeds FIFO_DEPTH.
- R8: A pop while the FIFO is empty sets err_underflow on the next clock edge.
- R9: The error flags stay set until a one is written to the matching err_clr bit. Bit 0 clears underflow and bit 1 clears overwrite.
- R10: An update request while an earlier one is still waiting to become active sets err_overwrite, and the newer settings replace the older ones.
- R11: busy stays high while enabled or while a burst is outstanding. After disable it falls once the last outstanding beat has arrived, and the FIFO is then emptied. A request is never raised while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Fetch enable |
| upd_req | input | 1 | One-cycle pulse that captures the configuration inputs |
| cfg_base | input | AW | Frame base byte address |
| cfg_frame_words | input | FW | Frame size in 32-bit words |
| cfg_line_words | input | LW | Visible line length in words |
| cfg_skip_bytes | input | SW | Bytes skipped after each visible line |
| cfg_burst_m1 | input | BW | Burst length minus one |
| cfg_pix_off | input | 5 | Starting bit inside the first word of a line |
| err_clr | input | 2 | Write-one-to-clear for the error flags |
| rd_gnt | input | 1 | Memory accepts the pending request |
| rd_dvalid | input | 1 | Read data beat valid |
| rd_data | input | DW | Read data beat |
| pix_pop | input | 1 | Consumer takes one word |
| rd_req | output | 1 | Burst request |
| rd_addr | output | AW | Burst start byte address |
| rd_len | output | BW | Burst length minus one |
| pix_data | output | DW | Word popped from the FIFO |
| pix_vld | output | 1 | pix_data holds a popped word |
| pix_off | output | 5 | Active pixel bit offset |
| fifo_lvl | output | $clog2(FIFO_DEPTH)+1 | FIFO fill level |
| busy | output | 1 | Engine active or draining |
| err_underflow | output | 1 | Sticky underflow flag |
| err_overwrite | output | 1 | Sticky overwrite flag |

## Verification
A corrupted column or address register shows up on rd_addr at the very next burst, and in the popped word stream a few cycles later. The bench compares every word of two whole frames against addresses it computes itself. A wrong remaining-word count shows within one frame, either as a burst that crosses a line or as a restart at the base address in the wrong place. A wrong fill level or threshold shows as a different settled fifo_lvl once popping stops. Errors in the update handshake show at the first frame boundary after the request, both in the data addresses and on pix_off.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_REQ  = 2'd1,
    AG_DATA = 2'd2
  } ag_state_e;

  localparam int ERR_UFL_BIT = 0;
  localparam int ERR_OVW_BIT = 1;

endpackage

// File: rtl/fbdma_cfg.sv
module fbdma_cfg #(
  parameter int AW        = 32,
  parameter int FW        = 20,
  parameter int LW        = 12,
  parameter int SW        = 16,
  parameter int BW        = 4,
  parameter int DEF_BURST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_req,
  input  logic          frm_start,
  input  logic [AW-1:0] in_base,
  input  logic [FW-1:0] in_frame,
  input  logic [LW-1:0] in_line,
  input  logic [SW-1:0] in_skip,
  input  logic [BW-1:0] in_bm1,
  input  logic [4:0]    in_poff,
  output logic [AW-1:0] act_base,
  output logic [FW-1:0] act_frame,
  output logic [LW-1:0] act_line,
  output logic [SW-1:0] act_skip,
  output logic [BW-1:0] act_bm1,
  output logic [4:0]    act_poff,
  output logic          pend,
  output logic          ovw_evt
);

  logic [AW-1:0] sh_base;
  logic [FW-1:0] sh_frame;
  logic [LW-1:0] sh_line;
  logic [SW-1:0] sh_skip;
  logic [BW-1:0] sh_bm1;
  logic [4:0]    sh_poff;
  logic          load;

  assign load    = pend && frm_start;
  assign ovw_evt = upd_req && pend && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_base   <= '0;
      sh_frame  <= '0;
      sh_line   <= '0;
      sh_skip   <= '0;
      sh_bm1    <= BW'(DEF_BURST - 1);
      sh_poff   <= '0;
      act_base  <= '0;
      act_frame <= '0;
      act_line  <= '0;
      act_skip  <= '0;
      act_bm1   <= BW'(DEF_BURST - 1);
      act_poff  <= '0;
      pend      <= 1'b0;
    end else begin
      if (load) begin
        act_base  <= sh_base;
        act_frame <= sh_frame;
        act_line  <= sh_line;
        act_skip  <= sh_skip;
        act_bm1   <= sh_bm1;
        act_poff  <= sh_poff;
        pend      <= 1'b0;
      end
      if (upd_req) begin
        sh_base  <= in_base;
        sh_frame <= in_frame;
        sh_line  <= in_line;
        sh_skip  <= in_skip;
        sh_bm1   <= in_bm1;
        sh_poff  <= in_poff;
        pend     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbdma_agen.sv
module fbdma_agen
  import fbdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int FW    = 20,
  parameter int LW    = 12,
  parameter int SW    = 16,
  parameter int BW    = 4,
  parameter int DEPTH = 512,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pend,
  input  logic [AW-1:0]    a_base,
  input  logic [FW-1:0]    a_frame,
  input  logic [LW-1:0]    a_line,
  input  logic [SW-1:0]    a_skip,
  input  logic [BW-1:0]    a_bm1,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic             rd_gnt,
  input  logic             rd_dvalid,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic [BW-1:0]    rd_len,
  output logic             push,
  output logic             frm_start,
  output logic             active
);

  localparam int CW = ((FW > LW) ? FW : LW) + 1;

  ag_state_e     st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] col_q;
  logic [FW-1:0] left_q;
  logic [BW:0]   beats_q;

  logic [CW-1:0]  burst_w, room_w, left_w, blen;
  logic [LVL_W:0] thr_w;
  logic           room_ok, line_end, frame_end;
  logic [AW-1:0]  step_w;

  always_comb begin
    burst_w = CW'(a_bm1) + CW'(1);
    room_w  = CW'(a_line) - CW'(col_q);
    left_w  = CW'(left_q);
    blen    = burst_w;
    if (room_w < blen) blen = room_w;
    if (left_w < blen) blen = left_w;
    thr_w     = (LVL_W+1)'(DEPTH - 5) - (LVL_W+1)'({a_bm1, 1'b0});
    room_ok   = ({1'b0, fifo_lvl} <= thr_w);
    line_end  = (room_w == blen);
    frame_end = (left_w == blen);
    step_w    = AW'({blen, 2'b00});
  end

  assign push   = (st == AG_DATA) && rd_dvalid;
  assign active = (st != AG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= AG_IDLE;
      addr_q    <= '0;
      col_q     <= '0;
      left_q    <= '0;
      beats_q   <= '0;
      frm_start <= 1'b1;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      rd_len    <= '0;
    end else begin
      unique case (st)
        AG_IDLE: begin
          if (!en) begin
            frm_start <= 1'b1;
          end else if (frm_start) begin
            if (!pend && (a_frame != '0) && (a_line != '0)) begin
              addr_q    <= a_base;
              col_q     <= '0;
              left_q    <= a_frame;
              frm_start <= 1'b0;
            end
          end else if (room_ok) begin
            rd_req  <= 1'b1;
            rd_addr <= addr_q;
            rd_len  <= BW'(blen - CW'(1));
            beats_q <= (BW+1)'(blen);
            left_q  <= left_q - FW'(blen);
            if (line_end) begin
              col_q  <= '0;
              addr_q <= addr_q + step_w + AW'(a_skip);
            end else begin
              col_q  <= col_q + LW'(blen);
              addr_q <= addr_q + step_w;
            end
            if (frame_end) frm_start <= 1'b1;
            st <= AG_REQ;
          end
        end
        AG_REQ: begin
          if (rd_gnt) begin
            rd_req <= 1'b0;
            st     <= AG_DATA;
          end else if (!en) begin
            rd_req    <= 1'b0;
            beats_q   <= '0;
            frm_start <= 1'b1;
            st        <= AG_IDLE;
          end
        end
        AG_DATA: begin
          if (rd_dvalid) begin
            beats_q <= beats_q - (BW+1)'(1);
            if (beats_q == (BW+1)'(1)) st <= AG_IDLE;
          end
        end
        default: st <= AG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbdma_fifo.sv
module fbdma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic             rvld,
  output logic [LVL_W-1:0] lvl,
  output logic             ufl_evt
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             wr_ok, rd_ok;

  assign wr_ok   = push && (lvl != LVL_W'(DEPTH)) && !flush;
  assign rd_ok   = pop && (lvl != '0) && !flush;
  assign ufl_evt = pop && (lvl == '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      lvl  <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + PTR_W'(1);
      if (rd_ok) rptr <= rptr + PTR_W'(1);
      lvl <= lvl + LVL_W'(wr_ok) - LVL_W'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rvld <= 1'b0;
    else     rvld <= rd_ok;
  end

endmodule

// File: rtl/fbdma_fetch.sv
module fbdma_fetch
  import fbdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FW         = 20,
  parameter int LW         = 12,
  parameter int SW         = 16,
  parameter int BW         = 4,
  parameter int DEF_BURST  = 8,
  parameter int FIFO_DEPTH = 512,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             upd_req,
  input  logic [AW-1:0]    cfg_base,
  input  logic [FW-1:0]    cfg_frame_words,
  input  logic [LW-1:0]    cfg_line_words,
  input  logic [SW-1:0]    cfg_skip_bytes,
  input  logic [BW-1:0]    cfg_burst_m1,
  input  logic [4:0]       cfg_pix_off,
  input  logic [1:0]       err_clr,
  input  logic             rd_gnt,
  input  logic             rd_dvalid,
  input  logic [DW-1:0]    rd_data,
  input  logic             pix_pop,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic [BW-1:0]    rd_len,
  output logic [DW-1:0]    pix_data,
  output logic             pix_vld,
  output logic [4:0]       pix_off,
  output logic [LVL_W-1:0] fifo_lvl,
  output logic             busy,
  output logic             err_underflow,
  output logic             err_overwrite
);

  logic [AW-1:0] a_base;
  logic [FW-1:0] a_frame;
  logic [LW-1:0] a_line;
  logic [SW-1:0] a_skip;
  logic [BW-1:0] a_bm1;
  logic          pend, ovw_evt, frm_start, ag_active, push, ufl_evt, flush;

  assign flush = !en && !ag_active;

  fbdma_cfg #(
    .AW(AW), .FW(FW), .LW(LW), .SW(SW), .BW(BW), .DEF_BURST(DEF_BURST)
  ) u_cfg (
    .clk(clk), .rst(rst), .upd_req(upd_req), .frm_start(frm_start),
    .in_base(cfg_base), .in_frame(cfg_frame_words), .in_line(cfg_line_words),
    .in_skip(cfg_skip_bytes), .in_bm1(cfg_burst_m1), .in_poff(cfg_pix_off),
    .act_base(a_base), .act_frame(a_frame), .act_line(a_line),
    .act_skip(a_skip), .act_bm1(a_bm1), .act_poff(pix_off),
    .pend(pend), .ovw_evt(ovw_evt)
  );

  fbdma_agen #(
    .AW(AW), .FW(FW), .LW(LW), .SW(SW), .BW(BW),
    .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_agen (
    .clk(clk), .rst(rst), .en(en), .pend(pend),
    .a_base(a_base), .a_frame(a_frame), .a_line(a_line),
    .a_skip(a_skip), .a_bm1(a_bm1), .fifo_lvl(fifo_lvl),
    .rd_gnt(rd_gnt), .rd_dvalid(rd_dvalid),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .push(push), .frm_start(frm_start), .active(ag_active)
  );

  fbdma_fifo #(
    .DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .wdata(rd_data),
    .pop(pix_pop), .rdata(pix_data), .rvld(pix_vld), .lvl(fifo_lvl),
    .ufl_evt(ufl_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      err_underflow <= 1'b0;
      err_overwrite <= 1'b0;
    end else begin
      busy          <= en || ag_active;
      err_underflow <= (err_underflow && !err_clr[ERR_UFL_BIT]) || ufl_evt;
      err_overwrite <= (err_overwrite && !err_clr[ERR_OVW_BIT]) || ovw_evt;
    end
  end

endmodule

// File: rtl/fbdma_fetch_chk.sv
module fbdma_fetch_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 512,
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             rd_req,
  input logic             rd_gnt,
  input logic [AW-1:0]    rd_addr,
  input logic             busy,
  input logic             pix_pop,
  input logic             pix_vld,
  input logic [LVL_W-1:0] fifo_lvl,
  input logic             err_underflow,
  input logic [1:0]       err_clr
);

  // R3: an ungranted request waits unchanged while enabled
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_gnt && en) |=> (rd_req && $stable(rd_addr)));

  // R7: fill level bounded by the FIFO depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_lvl <= LVL_W'(DEPTH));

  // R11: no request while idle
  p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R8: underflow flag rises only after a pop on an empty FIFO
  p_ufl_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_underflow) |-> $past(pix_pop && (fifo_lvl == '0)));

  // R9: flag is held until cleared
  p_ufl_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err_underflow && !err_clr[0]) |=> err_underflow);

  // R2: output word valid only after a pop
  p_vld_pop_r2: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> $past(pix_pop));

endmodule

bind fbdma_fetch fbdma_fetch_chk #(
  .AW(AW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .rd_req(rd_req), .rd_gnt(rd_gnt),
  .rd_addr(rd_addr), .busy(busy), .pix_pop(pix_pop), .pix_vld(pix_vld),
  .fifo_lvl(fifo_lvl), .err_underflow(err_underflow), .err_clr(err_clr)
);

// File: tb/fbdma_fetch_tb.sv
module fbdma_fetch_tb;

  localparam int DEPTH = 64;
  localparam int LVLW  = $clog2(DEPTH) + 1;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] frame;
    logic [11:0] line;
    logic [15:0] skip;
    logic [3:0]  bm1;
    logic [4:0]  poff;
    logic [4:0]  first_len;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000_1000, 20'd64, 12'd16, 16'd0,   4'd7,  5'd0,  5'd8},
    '{32'h0000_2000, 20'd30, 12'd10, 16'd24,  4'd3,  5'd8,  5'd4},
    '{32'h0000_3010, 20'd21, 12'd7,  16'd4,   4'd7,  5'd31, 5'd7},
    '{32'h0000_4000, 20'd12, 12'd12, 16'd100, 4'd15, 5'd5,  5'd12}
  };

  logic clk = 0, rst = 1, en = 0, upd_req = 0;
  logic [31:0] cfg_base = 0;
  logic [19:0] cfg_frame_words = 0;
  logic [11:0] cfg_line_words = 0;
  logic [15:0] cfg_skip_bytes = 0;
  logic [3:0]  cfg_burst_m1 = 0;
  logic [4:0]  cfg_pix_off = 0;
  logic [1:0]  err_clr = 0;
  logic rd_gnt = 0, rd_dvalid = 0, pix_pop = 0;
  logic [31:0] rd_data = 0;
  logic rd_req, pix_vld, busy, err_underflow, err_overwrite;
  logic [31:0] rd_addr, pix_data;
  logic [3:0]  rd_len;
  logic [4:0]  pix_off;
  logic [LVLW-1:0] fifo_lvl;

  fbdma_fetch #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .en(en), .upd_req(upd_req),
    .cfg_base(cfg_base), .cfg_frame_words(cfg_frame_words),
    .cfg_line_words(cfg_line_words), .cfg_skip_bytes(cfg_skip_bytes),
    .cfg_burst_m1(cfg_burst_m1), .cfg_pix_off(cfg_pix_off),
    .err_clr(err_clr), .rd_gnt(rd_gnt), .rd_dvalid(rd_dvalid),
    .rd_data(rd_data), .pix_pop(pix_pop), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_len(rd_len), .pix_data(pix_data),
    .pix_vld(pix_vld), .pix_off(pix_off), .fifo_lvl(fifo_lvl),
    .busy(busy), .err_underflow(err_underflow),
    .err_overwrite(err_overwrite)
  );

  always #2 clk = ~clk;

  int nchecks = 0, nerr = 0;
  bit done = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0000_5A5A;
  endfunction

  // memory model, stream recorder and consumer
  int m_cnt = 0, m_dly = 0, gcnt = 0;
  logic [31:0] m_addr = 0;
  int cur_base, cur_line, cur_skip, cur_bm1;
  bit chk_bursts = 0, first_flag = 0, cons_on = 0, man_pop = 0;
  int burst_bad = 0, first_len = 0, n = 0;
  logic [31:0] got [512];

  always @(posedge clk) begin
    rd_dvalid <= 1'b0;
    if (m_cnt > 0 && m_dly == 0) begin
      rd_dvalid <= 1'b1;
      rd_data   <= memf(m_addr);
      m_addr    <= m_addr + 4;
      m_cnt     <= m_cnt - 1;
    end else if (m_dly > 0) begin
      m_dly <= m_dly - 1;
    end
    if (rd_req && rd_gnt) begin
      m_addr <= rd_addr;
      m_cnt  <= int'(rd_len) + 1;
      m_dly  <= 2;
      if (first_flag) begin
        first_len  <= int'(rd_len) + 1;
        first_flag <= 0;
      end
      if (chk_bursts) begin
        int off, col;
        off = int'(rd_addr) - cur_base;
        col = (off % (4 * cur_line + cur_skip)) / 4;
        if ((int'(rd_len) > cur_bm1) || (col + int'(rd_len) + 1 > cur_line))
          burst_bad <= burst_bad + 1;
      end
    end
  end

  always @(negedge clk) begin
    gcnt   <= gcnt + 1;
    rd_gnt <= (gcnt % 3) != 0;
    pix_pop <= cons_on ? (fifo_lvl != 0) : man_pop;
    if (pix_vld) begin
      if (n < 512) got[n] = pix_data;
      n = n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_base = v.base; cfg_frame_words = v.frame; cfg_line_words = v.line;
    cfg_skip_bytes = v.skip; cfg_burst_m1 = v.bm1; cfg_pix_off = v.poff;
  endtask

  task automatic pulse_upd();
    upd_req = 1; tick(1); upd_req = 0;
  endtask

  task automatic wait_words(input int target);
    for (int t = 0; t < 20000 && n < target; t++) tick(1);
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 2000 && busy; t++) tick(1);
  endtask

  function automatic logic [31:0] exp_addr(input int b, input int l, input int s,
                                           input int k);
    return 32'(b + (k / l) * (4 * l + s) + 4 * (k % l));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 0;
    tick(2);
    // R1 reset state
    chk(!busy && !rd_req && !pix_vld && !err_underflow && !err_overwrite
        && fifo_lvl == 0 && pix_off == 0, "R1 reset state",
        {busy, rd_req, pix_vld, err_underflow, err_overwrite}, 0);

    // table of vectors
    for (int i = 0; i < 4; i++) begin
      vec_t v;
      int bad, bidx, f;
      v = VECS[i];
      f = int'(v.frame);
      set_cfg(v);
      pulse_upd();
      tick(2);
      chk(pix_off == v.poff, "R6 offset applied while stopped", pix_off, v.poff);
      cur_base = int'(v.base); cur_line = int'(v.line);
      cur_skip = int'(v.skip); cur_bm1 = int'(v.bm1);
      n = 0; burst_bad = 0; first_flag = 1; chk_bursts = 1; cons_on = 1;
      en = 1;
      wait_words(2 * f);
      cons_on = 0; en = 0; chk_bursts = 0;
      bad = 0; bidx = 0;
      for (int k = 0; k < f; k++)
        if (got[k] !== memf(exp_addr(cur_base, cur_line, cur_skip, k))) begin
          if (bad == 0) bidx = k;
          bad++;
        end
      chk(bad == 0, "R2 frame word stream", got[bidx],
          memf(exp_addr(cur_base, cur_line, cur_skip, bidx)));
      bad = 0; bidx = 0;
      for (int k = 0; k < f; k++)
        if (got[f + k] !== memf(exp_addr(cur_base, cur_line, cur_skip, k))) begin
          if (bad == 0) bidx = k;
          bad++;
        end
      chk(bad == 0, "R4 second frame restarts at base", got[f + bidx],
          memf(exp_addr(cur_base, cur_line, cur_skip, bidx)));
      chk(burst_bad == 0, "R3 burst size and line bound", burst_bad, 0);
      chk(first_len == int'(v.first_len), "R3 first burst length", first_len,
          v.first_len);
      wait_idle();
    end

    // R5 / R6: ignored inputs and mid-frame update
    set_cfg('{32'h1000, 20'd128, 12'd16, 16'd0, 4'd7, 5'd3, 5'd8});
    pulse_upd();
    tick(2);
    cfg_base = 32'h7000; cfg_pix_off = 5'd9;
    tick(3);
    chk(pix_off == 5'd3, "R5 offset unchanged without update", pix_off, 3);
    n = 0; cons_on = 1; en = 1;
    wait_words(10);
    pulse_upd();
    tick(1);
    chk(pix_off == 5'd3, "R6 offset held until frame start", pix_off, 3);
    wait_words(129);
    chk(got[0] === memf(32'h1000), "R5 base unchanged without update", got[0],
        memf(32'h1000));
    chk(got[127] === memf(32'h1000 + 508), "R6 old base until frame end",
        got[127], memf(32'h1000 + 508));
    chk(got[128] === memf(32'h7000), "R6 new base at next frame", got[128],
        memf(32'h7000));
    chk(pix_off == 5'd9, "R6 offset at next frame", pix_off, 9);
    cons_on = 0; en = 0;
    wait_idle();

    // R7 threshold
    set_cfg('{32'h1000, 20'd128, 12'd16, 16'd0, 4'd7, 5'd0, 5'd8});
    pulse_upd();
    tick(2);
    en = 1;
    tick(200);
    chk(fifo_lvl == 48, "R7 level settles above threshold", fifo_lvl, 48);
    chk(!rd_req, "R7 no request above threshold", rd_req, 0);

    // R10 overwrite
    cfg_base = 32'h9000;
    pulse_upd();
    tick(1);
    cfg_base = 32'hA000;
    pulse_upd();
    tick(2);
    chk(err_overwrite, "R10 second update sets overwrite", err_overwrite, 1);
    chk(!err_underflow, "R8 underflow untouched by update", err_underflow, 0);

    // R11 busy across disable
    cons_on = 1;
    for (int t = 0; t < 500 && !rd_req; t++) tick(1);
    cons_on = 0; en = 0;
    tick(2);
    chk(busy, "R11 busy while burst outstanding", busy, 1);
    wait_idle();
    tick(2);
    chk(!busy && fifo_lvl == 0, "R11 idle and flushed", {busy, fifo_lvl}, 0);
    chk(!rd_req, "R11 no request after disable", rd_req, 0);

    // R9 / R8 flags
    chk(err_overwrite, "R9 overwrite stays set", err_overwrite, 1);
    err_clr = 2'b10; tick(1); err_clr = 2'b00; tick(1);
    chk(!err_overwrite, "R9 overwrite cleared by bit 1", err_overwrite, 0);
    man_pop = 1; tick(1); man_pop = 0; tick(2);
    chk(err_underflow, "R8 pop on empty sets underflow", err_underflow, 1);
    err_clr = 2'b10; tick(1); err_clr = 2'b00; tick(4);
    chk(err_underflow, "R9 underflow kept by wrong clear bit", err_underflow, 1);
    err_clr = 2'b01; tick(1); err_clr = 2'b00; tick(1);
    chk(!err_underflow, "R9 underflow cleared by bit 0", err_underflow, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule